// File: doc/BRIEF.md
# PRBS-7 Test Pattern Injector

This block sits between the line encoder and the serializer of a 20-bit transmit path. In normal operation it forwards the encoded 20-bit word to the serializer input register. When the test enable is high, it puts a 2^7−1 pseudorandom sequence in place of that word. The pattern then passes through the rest of the transmit path unchanged. A far-end checker or a bit error rate tester can lock onto the sequence and count errors, because the sequence is fully deterministic.

The generator produces twenty sequence bits on every transmit clock, so the serial line carries one unbroken PRBS-7 stream. Bit 0 of each word holds the earliest bit, which suits a serializer that sends the least significant bit first. The generator keeps running whether or not test mode is on. Where the stream stands therefore depends only on the number of clocks since reset.

The path has no back-pressure: the serializer takes one word on every clock. For that reason the data ports carry no valid/ready handshake. The output is registered, with a latency of one clock from input to output.

Top module: `prbs_inj_top`

## Requirements
- R1: While `rst` is high at a clock edge, `ser_word` becomes all zeros after that edge, and the generator is reseeded.
- R2: When `prbs_en` is low at a clock edge, `ser_word` after that edge equals the `enc_word` sampled at that edge.
- R3: When `prbs_en` is high at a clock edge, `ser_word[i]` after that edge is sequence bit b[20k+i mod 127]. Here k is the number of clock edges since reset was released, counting from 0. The sequence is defined by b[-7..-1] = 1 and b[n] = b[n-6] XOR b[n-7], which is the polynomial x^7 + x^6 + 1. Bit 0 holds the earliest bit.
- R4: Two test words on consecutive clocks continue the stream without a gap. Bit 0 of the second word equals bit 14 XOR bit 13 of the first word.
- R5: The generator advances 20 sequence bits on every clock, including clocks with `prbs_en` low. After test mode is re-enabled, the word therefore follows from the clock count of R3.
- R6: While `prbs_en` is high, the value of `enc_word` has no effect on `ser_word`.
- R7: No test word is all zeros, because the generator never reaches the all-zero state.
- R8: A change on `prbs_en` takes effect on a whole word: the output word after an edge is either entirely test pattern or entirely `enc_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit word clock |
| rst | input | 1 | Synchronous reset, active high |
| prbs_en | input | 1 | High selects the PRBS-7 test pattern |
| enc_word | input | 20 | Encoded word from the line encoder |
| ser_word | output | 20 | Word to the serializer input register |

## Verification
The assertions assume that `rst` is high at the first clock edge and that `prbs_en` and `enc_word` are settled and free of X at every edge outside reset. The property checks on the sequence also assume that reset is not asserted between two words they compare, which is why they are disabled during reset. The bench drives every input on the falling clock edge, holds reset high for the first edges, and toggles `prbs_en` only between rising edges, so these assumptions always hold.

// File: rtl/prbs_inj_pkg.sv
package prbs_inj_pkg;
  localparam int WORD_W  = 20;
  localparam int LFSR_W  = 7;
  localparam int TAP_HI  = 7;   // x^7
  localparam int TAP_LO  = 6;   // x^6
  localparam logic [LFSR_W-1:0] SEED = '1;
endpackage

// File: rtl/prbs_inj_lfsr.sv
module prbs_inj_lfsr
  import prbs_inj_pkg::*;
#(
  parameter int W      = WORD_W,
  parameter int SW     = LFSR_W,
  parameter int TAP_A  = TAP_HI,
  parameter int TAP_B  = TAP_LO,
  parameter logic [SW-1:0] INIT = SEED
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] bits
);
  // st[j] holds the sequence bit generated j+1 steps ago
  localparam int IA = TAP_A - 1;
  localparam int IB = TAP_B - 1;

  logic [SW-1:0] st_q;
  logic [SW-1:0] st_next;

  always_comb begin
    logic [SW-1:0] walk;
    logic          fb;
    walk = st_q;
    bits = '0;
    for (int i = 0; i < W; i++) begin
      fb      = walk[IA] ^ walk[IB];
      bits[i] = fb;                 // earliest bit lands in bit 0
      walk    = {walk[SW-2:0], fb};
    end
    st_next = walk;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= INIT;
    else     st_q <= st_next;       // advances even when test mode is off
  end
endmodule

// File: rtl/prbs_inj_sel.sv
module prbs_inj_sel #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pick_test,
  input  logic [W-1:0] test_bits,
  input  logic [W-1:0] norm_bits,
  output logic [W-1:0] out_bits
);
  logic [W-1:0] out_q;

  always_ff @(posedge clk) begin
    if (rst)            out_q <= '0;
    else if (pick_test) out_q <= test_bits;
    else                out_q <= norm_bits;
  end

  assign out_bits = out_q;
endmodule

// File: rtl/prbs_inj_top.sv
module prbs_inj_top
  import prbs_inj_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         prbs_en,
  input  logic [W-1:0] enc_word,
  output logic [W-1:0] ser_word
);
  logic [W-1:0] pat_bits;

  prbs_inj_lfsr #(.W(W)) u_gen (
    .clk  (clk),
    .rst  (rst),
    .bits (pat_bits)
  );

  prbs_inj_sel #(.W(W)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .pick_test (prbs_en),
    .test_bits (pat_bits),
    .norm_bits (enc_word),
    .out_bits  (ser_word)
  );
endmodule

// File: rtl/prbs_inj_chk.sv
module prbs_inj_chk #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst,
  input logic         prbs_en,
  input logic [W-1:0] enc_word,
  input logic [W-1:0] ser_word
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (ser_word == '0));

  assert_passthru_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(prbs_en)) |-> (ser_word == $past(enc_word)));

  // inside a test word each bit follows the x^7 + x^6 + 1 recurrence
  assert_recur_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(prbs_en)) |->
      ((ser_word[W-1:7] ^ ser_word[W-7:1] ^ ser_word[W-8:0]) == '0));

  assert_join_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(prbs_en) && $past(prbs_en, 2)) |->
      (ser_word[0] == ($past(ser_word[W-6]) ^ $past(ser_word[W-7]))));

  assert_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(prbs_en)) |-> (ser_word != '0));
endmodule

bind prbs_inj_top prbs_inj_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .prbs_en  (prbs_en),
  .enc_word (enc_word),
  .ser_word (ser_word)
);

// File: tb/tb_prbs_inj_top.sv
`timescale 1ns/1ps
module tb_prbs_inj_top;
  localparam int W = 20;
  localparam int PER = 127;
  localparam int NV = 10;
  // each vector: {enable, encoded word}
  localparam logic [W:0] VEC [NV] = '{
    {1'b0, 20'hABCDE}, {1'b0, 20'h00000}, {1'b1, 20'h12345}, {1'b1, 20'hFFFFF},
    {1'b1, 20'h0F0F0}, {1'b0, 20'h5A5A5}, {1'b0, 20'hFFFFF}, {1'b1, 20'h00001},
    {1'b1, 20'hC3C3C}, {1'b0, 20'h80000}
  };

  logic clk = 0, rst = 1, prbs_en = 0;
  logic [W-1:0] enc_word = '0;
  logic [W-1:0] ser_word;
  int n_chk = 0, n_fail = 0, k = 0;
  logic refb [PER];

  always #2.5 clk = ~clk;

  prbs_inj_top dut (.clk(clk), .rst(rst), .prbs_en(prbs_en),
                    .enc_word(enc_word), .ser_word(ser_word));

  function automatic logic [W-1:0] ref_word(int idx);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = refb[(W*idx + i) % PER];
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on falling edge, one rising edge, sample on next falling edge
  task automatic step(logic en, logic [W-1:0] d);
    prbs_en = en; enc_word = d;
    @(posedge clk); @(negedge clk);
    k++;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic h [PER + 7];
    logic [W-1:0] prev;
    for (int i = 0; i < 7; i++) h[i] = 1'b1;
    for (int n = 7; n < PER + 7; n++) h[n] = h[n-6] ^ h[n-7];
    for (int n = 0; n < PER; n++) refb[n] = h[n+7];

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset output", ser_word, '0);
    rst = 0;

    // table walk
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][W], VEC[v][W-1:0]);
      if (VEC[v][W]) check("R3/R5/R6 vector test word", ser_word, ref_word(k-1));
      else           check("R2/R8 vector pass-through", ser_word, VEC[v][W-1:0]);
    end

    // long run: period and continuity
    for (int j = 0; j < 140; j++) begin
      prev = ser_word;
      step(1'b1, W'(j * 37));
      check("R3 long run word", ser_word, ref_word(k-1));
      if (j > 0) check("R4 word join", W'(ser_word[0]), W'(prev[14] ^ prev[13]));
      if (ser_word == '0) check("R7 nonzero", ser_word, ~W'(0));
    end

    // data ignored in test mode: two data values, same clock index pattern
    step(1'b1, 20'h00000);
    check("R6 data zero", ser_word, ref_word(k-1));
    step(1'b1, 20'hFFFFF);
    check("R6 data ones", ser_word, ref_word(k-1));

    // generator runs while off
    for (int j = 0; j < 5; j++) step(1'b0, 20'h3C3C3);
    check("R2 off word", ser_word, 20'h3C3C3);
    step(1'b1, 20'h3C3C3);
    check("R5 resume position", ser_word, ref_word(k-1));
    step(1'b0, 20'h11111);
    check("R8 switch off boundary", ser_word, 20'h11111);

    // mid-run reset reseeds
    rst = 1;
    step(1'b1, 20'h22222);
    check("R1 reset mid-run", ser_word, '0);
    rst = 0; k = 0;
    step(1'b1, 20'h22222);
    check("R1 reseeded first word", ser_word, ref_word(0));
    step(1'b1, 20'h22222);
    check("R3 second word after reseed", ser_word, ref_word(1));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule